// File: doc/BRIEF.md
# Back-to-Back Cache Line-Fill Sequencer

This block fetches two cache lines, one after the other, over a burst-capable read bus. A fill request carries two line addresses. For each line the sequencer drives an address strobe and then collects a burst of data beats. By default a line is 32 bytes, carried as four 8-byte beats on a 64-bit bus. Each accepted beat goes out on a registered fill port, tagged with its line index and beat index. A one-cycle done pulse marks the last beat of each line.

The second burst can be issued in two ways. If the bus signals next-address during the first burst, the second address is strobed while the first burst's data is still arriving, so the second line's data follows with no idle cycle. Otherwise the second strobe waits until the first burst has finished. The sequencer holds back every address strobe while any of these is high: a higher-priority access request, an address-hold, or a backoff. A backoff during a data phase aborts the current burst and restarts it from its first beat. While a fill is in flight the sequencer accepts no new request.

Top module: `line_fill_seq`

## Requirements
- R1: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only when the sequencer is idle, and it stays low from the accepting edge until the second line's done pulse has been issued.
- R2: Every address strobe presents a line address with its low offset bits (5 bits at default parameters) at zero. Strobes follow the order first line (`req_line0`) then second line (`req_line1`), and the same order applies after any restart.
- R3: `bus_ads` is never high in a cycle where `prio_req`, `bus_ahold` or `bus_boff` is high. A pending strobe waits until all three are low.
- R4: A beat is accepted only on an edge where the sequencer is in a data phase, `bus_rdy` is high and `bus_boff` is low. The beat appears one cycle later on `fill_data`, with `fill_valid` high, `fill_beat` giving its index (0 to BEATS-1, in order) and `fill_line` at 0 for the first line and 1 for the second.
- R5: With pipelining enabled, if `bus_nxt_addr` is high in a cycle of the first burst's data phase with no stall, the second strobe is issued before the first burst ends. The second burst's first beat is then accepted on the edge directly after the first burst's last beat.
- R6: If `bus_nxt_addr` stays low through the first burst, there is no second strobe while that burst is outstanding. The earliest second strobe comes in the cycle after the first burst's last beat, so the second line's first beat is accepted no earlier than two edges after the first line's last beat.
- R7: `bus_boff` high during a data phase aborts the current burst. The beat index returns to 0, an early-issued second address is dropped, and the burst is strobed again for the same line once the stall clears.
- R8: `line_done` pulses for one cycle together with the fill output of beat BEATS-1 of each line. It pulses exactly twice per request, and only after BEATS consecutive beats of that line.
- R9: While reset is held, and after it is released, `req_ready` is high and `bus_ads`, `fill_valid` and `line_done` are low. Reset is asserted asynchronously and released through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Fill request present |
| req_line0 | input | LINE_ADDR_W | Line address fetched first |
| req_line1 | input | LINE_ADDR_W | Line address fetched second |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| prio_req | input | 1 | Higher-priority access pending; holds back strobes |
| bus_rdy | input | 1 | Beat ready on the data bus |
| bus_nxt_addr | input | 1 | Bus can take the next address now |
| bus_ahold | input | 1 | Address hold; holds back strobes |
| bus_boff | input | 1 | Backoff; aborts data phase, holds back strobes |
| bus_data | input | DATA_W | Read data beat |
| bus_ads | output | 1 | Address strobe |
| bus_addr | output | LINE_ADDR_W+OFF_W | Byte address of the line being strobed |
| fill_valid | output | 1 | Accepted beat on the fill port |
| fill_line | output | 1 | 0 for first line, 1 for second |
| fill_beat | output | BEAT_W | Beat index within the line |
| fill_data | output | DATA_W | Beat data |
| line_done | output | 1 | Last beat of a line delivered |

## Verification
The bench builds the sequencer with a 12-bit line address, a 64-bit data bus, four beats per line and pipelining enabled. The short address makes each line's data pattern easy to tell apart. With four beats, a backoff can be placed early in either burst, and turning next-address on or off selects the pipelined or the waiting issue path. A bus responder model serves strobed addresses in order. The scoreboard compares every beat's data and tags, and it measures the edge distance between the two bursts so that the one-cycle and two-cycle spacings can be told apart.

// File: rtl/lfs_pkg.sv
package lfs_pkg;

  typedef enum logic [1:0] {
    LFS_IDLE  = 2'd0,
    LFS_ISSUE = 2'd1,
    LFS_DATA  = 2'd2
  } lfs_state_e;

endpackage

// File: rtl/lfs_rst_sync.sv
module lfs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/lfs_beat_ctr.sv
module lfs_beat_ctr #(
  parameter  int BEATS = 4,
  localparam int CW    = $clog2(BEATS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          at_last
);

  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d = cnt;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt + CW'(1);
  end

  assign cnt_en = clr | inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  assign at_last = (cnt == CW'(BEATS-1));

  // R4: the index only moves on an accepted beat
  a_r4_hold_without_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt));

  // R7: an abort or line end brings the index back to the first beat
  a_r7_clear_to_first: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0));

endmodule

// File: rtl/lfs_fill_out.sv
module lfs_fill_out #(
  parameter  int DATA_W = 64,
  parameter  int BEATS  = 4,
  localparam int BEAT_W = $clog2(BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              take_last,
  input  logic              line_in,
  input  logic [BEAT_W-1:0] beat_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              fill_valid,
  output logic              fill_line,
  output logic [BEAT_W-1:0] fill_beat,
  output logic [DATA_W-1:0] fill_data,
  output logic              line_done
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_valid <= 1'b0;
      line_done  <= 1'b0;
    end else begin
      fill_valid <= take;
      line_done  <= take_last;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      fill_line <= line_in;
      fill_beat <= beat_in;
      fill_data <= data_in;
    end
  end

  // R8: the done pulse rides on the final beat of a line
  a_r8_done_on_last_beat: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |-> (fill_valid && fill_beat == BEAT_W'(BEATS-1)));

  // R4: every accepted beat shows up on the next cycle
  a_r4_beat_reaches_port: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> fill_valid);

endmodule

// File: rtl/line_fill_seq.sv
module line_fill_seq
  import lfs_pkg::*;
#(
  parameter  int LINE_ADDR_W = 27,
  parameter  int DATA_W      = 64,
  parameter  int BEATS       = 4,
  parameter  bit PIPE_EN     = 1'b1,
  localparam int OFF_W       = $clog2(BEATS*DATA_W/8),
  localparam int ADDR_W      = LINE_ADDR_W + OFF_W,
  localparam int BEAT_W      = $clog2(BEATS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [LINE_ADDR_W-1:0] req_line0,
  input  logic [LINE_ADDR_W-1:0] req_line1,
  output logic                   req_ready,
  input  logic                   prio_req,
  input  logic                   bus_rdy,
  input  logic                   bus_nxt_addr,
  input  logic                   bus_ahold,
  input  logic                   bus_boff,
  input  logic [DATA_W-1:0]      bus_data,
  output logic                   bus_ads,
  output logic [ADDR_W-1:0]      bus_addr,
  output logic                   fill_valid,
  output logic                   fill_line,
  output logic [BEAT_W-1:0]      fill_beat,
  output logic [DATA_W-1:0]      fill_data,
  output logic                   line_done
);

  logic                   srst_n;
  lfs_state_e             st_q, st_d;
  logic                   cur_q, cur_d;
  logic                   pipe_q, pipe_d;
  logic                   na_q, na_d;
  logic [LINE_ADDR_W-1:0] line0_q, line1_q;
  logic [LINE_ADDR_W-1:0] strobe_line;
  logic                   stall, in_data, accept;
  logic                   take, take_last;
  logic                   ads_issue, ads_pipe;
  logic                   ctr_clr, ctr_inc;
  logic [BEAT_W-1:0]      beat;
  logic                   at_last;

  lfs_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  assign req_ready = (st_q == LFS_IDLE);
  assign accept    = req_ready && req_valid;
  assign stall     = prio_req | bus_ahold | bus_boff;
  assign in_data   = (st_q == LFS_DATA);
  assign take      = in_data & bus_rdy & ~bus_boff;
  assign take_last = take & at_last;
  assign ads_issue = (st_q == LFS_ISSUE) & ~stall;

  generate
    if (PIPE_EN) begin : g_pipe
      assign ads_pipe = in_data & ~cur_q & ~pipe_q & (na_q | bus_nxt_addr) & ~stall;
    end else begin : g_no_pipe
      assign ads_pipe = 1'b0;
    end
  endgenerate

  assign bus_ads     = ads_issue | ads_pipe;
  assign strobe_line = (ads_pipe | cur_q) ? line1_q : line0_q;
  assign bus_addr    = {strobe_line, {OFF_W{1'b0}}};

  assign ctr_inc = take;
  assign ctr_clr = (in_data & bus_boff) | take_last;

  lfs_beat_ctr #(.BEATS(BEATS)) u_beat_ctr (
    .clk     (clk),
    .rst_n   (srst_n),
    .clr     (ctr_clr),
    .inc     (ctr_inc),
    .cnt     (beat),
    .at_last (at_last)
  );

  always_comb begin
    st_d   = st_q;
    cur_d  = cur_q;
    pipe_d = pipe_q;
    na_d   = na_q;
    case (st_q)
      LFS_IDLE: begin
        if (req_valid) begin
          st_d   = LFS_ISSUE;
          cur_d  = 1'b0;
          pipe_d = 1'b0;
          na_d   = 1'b0;
        end
      end
      LFS_ISSUE: begin
        if (!stall) st_d = LFS_DATA;
      end
      LFS_DATA: begin
        if (bus_boff) begin
          st_d   = LFS_ISSUE;
          pipe_d = 1'b0;
          na_d   = 1'b0;
        end else begin
          if (!cur_q && bus_nxt_addr) na_d = 1'b1;
          if (ads_pipe) pipe_d = 1'b1;
          if (take_last) begin
            pipe_d = 1'b0;
            na_d   = 1'b0;
            if (!cur_q) begin
              cur_d = 1'b1;
              st_d  = (pipe_q || ads_pipe) ? LFS_DATA : LFS_ISSUE;
            end else begin
              st_d  = LFS_IDLE;
            end
          end
        end
      end
      default: st_d = LFS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q   <= LFS_IDLE;
      cur_q  <= 1'b0;
      pipe_q <= 1'b0;
      na_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cur_q  <= cur_d;
      pipe_q <= pipe_d;
      na_q   <= na_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      line0_q <= req_line0;
      line1_q <= req_line1;
    end
  end

  lfs_fill_out #(.DATA_W(DATA_W), .BEATS(BEATS)) u_fill_out (
    .clk        (clk),
    .rst_n      (srst_n),
    .take       (take),
    .take_last  (take_last),
    .line_in    (cur_q),
    .beat_in    (beat),
    .data_in    (bus_data),
    .fill_valid (fill_valid),
    .fill_line  (fill_line),
    .fill_beat  (fill_beat),
    .fill_data  (fill_data),
    .line_done  (line_done)
  );

  // R3: no strobe while any stall source is up
  a_r3_no_strobe_when_stalled: assert property (@(posedge clk) disable iff (!srst_n)
    bus_ads |-> !(prio_req || bus_ahold || bus_boff));

  // R1: a taken request closes the request port
  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!srst_n)
    accept |=> !req_ready);

  // R7: backoff in a data phase returns to address issue and forgets the early address
  a_r7_abort_to_issue: assert property (@(posedge clk) disable iff (!srst_n)
    (in_data && bus_boff) |=> (st_q == LFS_ISSUE && !pipe_q));

  // R6: without next-address, no second strobe during the first burst
  a_r6_no_early_second: assert property (@(posedge clk) disable iff (!srst_n)
    (in_data && !cur_q && !na_q && !bus_nxt_addr) |-> !bus_ads);

endmodule

// File: tb/line_fill_seq_bench.sv
`timescale 1ns/1ps
module line_fill_seq_bench;

  localparam int LA  = 12;
  localparam int DW  = 64;
  localparam int NB  = 4;
  localparam int OFF = $clog2(NB*DW/8);
  localparam int AW  = LA + OFF;
  localparam int BW  = $clog2(NB);

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          req_valid;
  logic [LA-1:0] req_line0, req_line1;
  logic          req_ready;
  logic          prio_req, bus_rdy, bus_nxt_addr, bus_ahold, bus_boff;
  logic [DW-1:0] bus_data;
  logic          bus_ads;
  logic [AW-1:0] bus_addr;
  logic          fill_valid, fill_line, line_done;
  logic [BW-1:0] fill_beat;
  logic [DW-1:0] fill_data;

  line_fill_seq #(.LINE_ADDR_W(LA), .DATA_W(DW), .BEATS(NB), .PIPE_EN(1'b1)) u_line_fill_seq (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_line0 (req_line0), .req_line1 (req_line1), .req_ready (req_ready),
    .prio_req (prio_req), .bus_rdy (bus_rdy), .bus_nxt_addr (bus_nxt_addr),
    .bus_ahold (bus_ahold), .bus_boff (bus_boff), .bus_data (bus_data),
    .bus_ads (bus_ads), .bus_addr (bus_addr),
    .fill_valid (fill_valid), .fill_line (fill_line), .fill_beat (fill_beat),
    .fill_data (fill_data), .line_done (line_done)
  );

  typedef struct {
    logic          line;
    logic [LA-1:0] addr;
  } exp_t;

  exp_t          exp_q[$];
  logic [AW-1:0] aq[$];
  int  rbeat, cyc, n_chk, n_fail, rdy_mode, run_beats, restarts, dones, n_ads;
  int  t_done0, t_first1;
  bit  rdy_tog, na_scn, pipe_seen, first1_seen, live;

  function automatic logic [DW-1:0] beat_word(logic [LA-1:0] a, int b);
    logic [1:0] bb;
    bb = b[1:0];
    return {20'h0, a, 16'hC0DE, 14'h0, bb};
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // scoreboard monitor and bus responder
  always @(negedge clk) begin
    int pre;
    int idx;
    pre = aq.size();
    cyc++;
    if (live) begin
      if (fill_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4", "beat with nothing pending", 64'd1, 64'd0);
        end else begin
          check(fill_line == exp_q[0].line, "R4", "line index", 64'(fill_line), 64'(exp_q[0].line));
          check(fill_data == beat_word(exp_q[0].addr, int'(fill_beat)), "R4", "beat data",
                fill_data, beat_word(exp_q[0].addr, int'(fill_beat)));
          if (fill_beat == '0 && run_beats != 0) restarts++;
          else check(int'(fill_beat) == run_beats, "R4", "beat order", 64'(fill_beat), 64'(run_beats));
          run_beats = int'(fill_beat) + 1;
          if (!fill_line && line_done) t_done0 = cyc;
          if (fill_line && fill_beat == '0 && !first1_seen) begin
            first1_seen = 1'b1;
            t_first1    = cyc;
          end
          if (line_done) begin
            check(run_beats == NB, "R8", "beats before done", 64'(run_beats), 64'(NB));
            void'(exp_q.pop_front());
            run_beats = 0;
            dones++;
          end
        end
      end else if (line_done) begin
        check(1'b0, "R8", "done without a beat", 64'd1, 64'd0);
      end
    end
    rdy_tog = ~rdy_tog;
    bus_rdy = (pre > 0) && (rdy_mode == 0 || rdy_tog);
    bus_data = bus_rdy ? beat_word(aq[0][AW-1:OFF], rbeat) : '1;
    if (bus_boff) begin
      aq.delete();
      rbeat = 0;
    end else if (bus_rdy) begin
      rbeat++;
      if (rbeat == NB) begin
        void'(aq.pop_front());
        rbeat = 0;
      end
    end
    if (live && bus_ads) begin
      n_ads++;
      check(!(prio_req || bus_ahold || bus_boff), "R3", "strobe during stall", 64'd1, 64'd0);
      check(bus_addr[OFF-1:0] == '0, "R2", "offset bits", 64'(bus_addr[OFF-1:0]), 64'd0);
      idx = (pre > 0) ? 1 : 0;
      if (exp_q.size() > idx)
        check(bus_addr[AW-1:OFF] == exp_q[idx].addr, "R2", "strobe address",
              64'(bus_addr[AW-1:OFF]), 64'(exp_q[idx].addr));
      else
        check(1'b0, "R2", "unexpected strobe", 64'(bus_addr), 64'd0);
      if (pre > 0) begin
        pipe_seen = 1'b1;
        if (na_scn) check(1'b0, "R6", "strobe during burst with next-address low", 64'(pre), 64'd0);
      end
      aq.push_back(bus_addr);
    end
  end

  task automatic send(logic [LA-1:0] a0, logic [LA-1:0] a1);
    exp_t e;
    @(posedge clk); #1;
    req_valid = 1'b1;
    req_line0 = a0;
    req_line1 = a1;
    do @(negedge clk); while (!req_ready);
    e.line = 1'b0; e.addr = a0; exp_q.push_back(e);
    e.line = 1'b1; e.addr = a1; exp_q.push_back(e);
    @(posedge clk); #1;
    req_valid = 1'b0;
    req_line0 = '1;
    req_line1 = '1;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(req_ready && exp_q.size() == 0));
  endtask

  task automatic wait_beat(logic l, int b);
    do @(negedge clk); while (!(fill_valid && fill_line == l && int'(fill_beat) == b));
  endtask

  task automatic new_run();
    first1_seen = 1'b0;
    pipe_seen   = 1'b0;
    dones       = 0;
    restarts    = 0;
    n_ads       = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_line0 = '0; req_line1 = '0;
    prio_req = 1'b0; bus_nxt_addr = 1'b0; bus_ahold = 1'b0; bus_boff = 1'b0;
    rdy_mode = 0; live = 1'b0; na_scn = 1'b0;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b1, "R9", "ready in reset", 64'(req_ready), 64'd1);
    check(!bus_ads && !fill_valid && !line_done, "R9", "quiet in reset",
          64'({bus_ads, fill_valid, line_done}), 64'd0);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready && !bus_ads && !fill_valid, "R9", "idle after release",
          64'({req_ready, bus_ads, fill_valid}), 64'd4);
    live = 1'b1;

    // waiting issue: next-address low
    new_run(); na_scn = 1'b1; bus_nxt_addr = 1'b0;
    send(12'h0A1, 12'h0A2);
    @(negedge clk);
    check(!req_ready, "R1", "busy after accept", 64'(req_ready), 64'd0);
    wait_idle();
    check(t_first1 - t_done0 == 2, "R6", "gap between bursts", 64'(t_first1 - t_done0), 64'd2);
    check(dones == 2, "R8", "done pulses", 64'(dones), 64'd2);
    check(req_ready, "R1", "ready after second done", 64'(req_ready), 64'd1);

    // pipelined issue
    new_run(); na_scn = 1'b0; bus_nxt_addr = 1'b1;
    send(12'h3C4, 12'h3C5);
    wait_idle();
    check(pipe_seen, "R5", "second strobe during first burst", 64'(pipe_seen), 64'd1);
    check(t_first1 - t_done0 == 1, "R5", "no idle between bursts", 64'(t_first1 - t_done0), 64'd1);
    check(dones == 2, "R8", "done pulses", 64'(dones), 64'd2);

    // priority stall with sparse ready
    new_run(); rdy_mode = 1; bus_nxt_addr = 1'b0; na_scn = 1'b1;
    @(posedge clk); #1; prio_req = 1'b1;
    send(12'h777, 12'h001);
    repeat (6) @(negedge clk);
    check(n_ads == 0, "R3", "strobes while priority pending", 64'(n_ads), 64'd0);
    @(posedge clk); #1; prio_req = 1'b0;
    wait_idle();
    check(n_ads == 2, "R3", "strobes after priority release", 64'(n_ads), 64'd2);
    check(dones == 2, "R4", "sparse ready fill complete", 64'(dones), 64'd2);
    rdy_mode = 0;

    // address hold between bursts
    new_run();
    send(12'h250, 12'h251);
    wait_beat(1'b0, 1);
    @(posedge clk); #1; bus_ahold = 1'b1;
    repeat (5) @(posedge clk);
    #1; bus_ahold = 1'b0;
    wait_idle();
    check(t_first1 - t_done0 > 2, "R3", "hold delays second burst", 64'(t_first1 - t_done0), 64'd3);
    check(n_ads == 2, "R3", "one strobe per line", 64'(n_ads), 64'd2);

    // backoff in first burst with pipelining
    new_run(); na_scn = 1'b0; bus_nxt_addr = 1'b1;
    send(12'h5E0, 12'h5E1);
    wait_beat(1'b0, 1);
    @(posedge clk); #1; bus_boff = 1'b1;
    repeat (3) @(posedge clk);
    #1; bus_boff = 1'b0;
    wait_idle();
    check(restarts >= 1, "R7", "first burst restarted", 64'(restarts), 64'd1);
    check(n_ads == 4, "R7", "both addresses strobed again", 64'(n_ads), 64'd4);
    check(dones == 2, "R8", "done pulses after restart", 64'(dones), 64'd2);

    // backoff in second burst without pipelining
    new_run(); na_scn = 1'b1; bus_nxt_addr = 1'b0;
    send(12'h0F0, 12'h0F1);
    wait_beat(1'b1, 0);
    @(posedge clk); #1; bus_boff = 1'b1;
    repeat (2) @(posedge clk);
    #1; bus_boff = 1'b0;
    wait_idle();
    check(restarts >= 1, "R7", "second burst restarted", 64'(restarts), 64'd1);
    check(n_ads == 3, "R7", "only second line strobed again", 64'(n_ads), 64'd3);
    check(dones == 2, "R8", "done pulses after late restart", 64'(dones), 64'd2);

    repeat (4) @(negedge clk);
    report();
  end

endmodule